// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block takes the two wires of a low-speed USB differential pair, sampled by a system clock that runs at ten times the bit rate, and turns a packet on the wires into a stream of bytes. The wires first pass through a two-flop synchronizer. The block then waits for activity and looks for J-to-K transitions inside the sync field. It sets its sampling phase from the most recent such transition, and it locks when it sees two K bits in a row.

Once locked, the block takes one sample per bit. It decodes the samples as NRZI, drops the bit that follows every run of six ones, and assembles bytes least significant bit first. Each completed byte comes out with a one-clock valid pulse. A single-ended zero in any bit slot except the first slot of a byte ends the packet. A single-ended zero in the first slot is treated as a K level, because hubs can leave a dribble bit there. The block also reports two errors, each as a one-clock pulse: a packet that carries too many bytes, and a sync field that never completes.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is held and in the cycle after it is released, rx_valid_o, rx_eop_o, rx_ovf_o and rx_sync_err_o are all 0.
- R2: The block locks only when a J-to-K transition is followed by a K sample one and a half bit times later. A K bit followed by a J bit does not lock, and searching continues. A sync field with extra leading K/J pairs still yields the correct bytes.
- R3: After lock, the block takes one sample per 10 clocks. A data bit is 1 when the sampled level (D-, 1 = J) equals the previous level, and 0 otherwise. The last K of the sync field is the first previous level. Bits fill each byte LSB first, and each complete byte is shown on rx_byte_o together with a one-clock rx_valid_o pulse.
- R4: After six consecutive decoded 1 bits, the next bit slot is discarded. The run counter is cleared by a decoded 0 and by a discarded slot. It is not cleared at byte boundaries.
- R5: A single-ended zero (D+ = 0, D- = 0) sampled in bit slots 1 to 7 of a byte gives a one-clock rx_eop_o pulse. The partial byte is dropped, and the block returns to idle.
- R6: A single-ended zero sampled in bit slot 0 of a byte does not end the packet. It is decoded as a K level, so the byte is still delivered.
- R7: When byte MAX_BYTES+1 completes, that byte is not output. Instead rx_ovf_o pulses for one clock, no rx_eop_o follows, and the block ignores the line until a single-ended zero appears. The next packet is then received normally.
- R8: If the block has not locked within SYNC_TMO clocks of the first K after idle, rx_sync_err_o pulses for one clock, no bytes are output, and the block returns to idle.
- R9: At most one of rx_valid_o, rx_eop_o, rx_ovf_o and rx_sync_err_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, ten times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| usb_dp_i | input | 1 | D+ line, asynchronous |
| usb_dm_i | input | 1 | D- line, asynchronous |
| rx_valid_o | output | 1 | One-clock pulse when a byte is complete |
| rx_byte_o | output | 8 | Received byte, valid with rx_valid_o |
| rx_eop_o | output | 1 | One-clock pulse at end of packet |
| rx_ovf_o | output | 1 | One-clock pulse when the byte limit is exceeded |
| rx_sync_err_o | output | 1 | One-clock pulse when sync is not found in time |

## Verification
The hardest cases to reach from the pins are a single-ended zero placed exactly in bit slot 0 partway through a packet, and a stuffed bit that falls across a byte boundary. Both depend on the line level and the run of ones left over from earlier bytes. The bench therefore drives the wires through its own NRZI encoder, which tracks the current level and the ones run bit by bit. The bench inserts stuffed bits itself and can replace any chosen slot with a single-ended zero. From the same tracked level it computes the bit value that the receiver must decode in that replaced slot.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HUNT  = 2'd1,
    ST_RX    = 2'd2,
    ST_DRAIN = 2'd3
  } rx_state_t;

  // K: D+ high, D- low
  function automatic logic line_is_k(input logic dp, input logic dm);
    return dp & ~dm;
  endfunction

  // J (idle): D+ low, D- high
  function automatic logic line_is_j(input logic dp, input logic dm);
    return ~dp & dm;
  endfunction

  function automatic logic line_is_se0(input logic dp, input logic dm);
    return ~dp & ~dm;
  endfunction

endpackage

// File: rtl/usb_rx_insync.sv
module usb_rx_insync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL[b]}};
        else     chain <= {chain[STAGES-2:0], async_i[b]};
      end
      assign sync_o[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/usb_rx_ctrl.sv
module usb_rx_ctrl
  import usb_rx_pkg::*;
#(
  parameter int OVS      = 10,
  parameter int SYNC_TMO = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic dp_i,
  input  logic dm_i,
  input  logic end_i,
  input  logic ovf_i,
  output logic start_o,
  output logic stb_o,
  output logic lvl_o,
  output logic se0_o,
  output logic sync_err_o
);

  localparam int HALF    = OVS / 2;
  localparam int LOCK_AT = OVS + HALF;
  localparam int CW      = $clog2(LOCK_AT + 2);
  localparam int TW      = $clog2(SYNC_TMO + 1);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [TW-1:0] tmo;
  logic          prev_j;
  logic          ln_k, ln_j, ln_se0, jk_edge;

  assign ln_k    = line_is_k(dp_i, dm_i);
  assign ln_j    = line_is_j(dp_i, dm_i);
  assign ln_se0  = line_is_se0(dp_i, dm_i);
  assign jk_edge = prev_j & ln_k;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      tmo        <= '0;
      prev_j     <= 1'b1;
      start_o    <= 1'b0;
      stb_o      <= 1'b0;
      lvl_o      <= 1'b1;
      se0_o      <= 1'b0;
      sync_err_o <= 1'b0;
    end else begin
      prev_j     <= ln_j;
      start_o    <= 1'b0;
      stb_o      <= 1'b0;
      sync_err_o <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (jk_edge) begin
            st  <= ST_HUNT;
            cnt <= '0;
            tmo <= '0;
          end
        end
        ST_HUNT: begin
          tmo <= tmo + 1'b1;
          if (tmo == TW'(SYNC_TMO - 1)) begin
            st         <= ST_IDLE;
            sync_err_o <= 1'b1;
          end else if (jk_edge) begin
            cnt <= '0;
          end else if (cnt == CW'(LOCK_AT)) begin
            if (ln_k) begin
              st      <= ST_RX;
              cnt     <= '0;
              start_o <= 1'b1;
            end else begin
              cnt <= CW'(LOCK_AT + 1);
            end
          end else if (cnt < CW'(LOCK_AT)) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RX: begin
          if (end_i) begin
            st <= ST_IDLE;
          end else if (ovf_i) begin
            st <= ST_DRAIN;
          end else if (cnt == CW'(OVS - 1)) begin
            cnt   <= '0;
            stb_o <= 1'b1;
            lvl_o <= dm_i;
            se0_o <= ln_se0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (ln_se0) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: receive state is entered only from the sync hunt
  a_r2_lock_from_hunt: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RX && $past(st) != ST_RX) |-> $past(st) == ST_HUNT);

  // R8: hunting never outlasts the timeout window
  a_r8_hunt_bounded: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HUNT) |-> (tmo < TW'(SYNC_TMO)));

  // R3: one sample strobe per bit, never back to back
  a_r3_strobe_spacing: assert property (@(posedge clk) disable iff (rst)
    stb_o |=> !stb_o);

endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser #(
  parameter int DW        = 8,
  parameter int MAX_BYTES = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          stb_i,
  input  logic          lvl_i,
  input  logic          se0_i,
  output logic          end_o,
  output logic          ovf_hit_o,
  output logic          valid_o,
  output logic [DW-1:0] byte_o,
  output logic          eop_o,
  output logic          ovf_o
);

  localparam int BW = $clog2(DW);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam int NW = $clog2(MAX_BYTES + 1);

  logic          prev;
  logic [OW-1:0] ones;
  logic [BW-1:0] bpos;
  logic [NW-1:0] nbytes;
  logic [DW-1:0] sh;
  logic          bit_d, stuffed, kill, last_bit, full;
  logic [DW-1:0] nxt;

  assign bit_d     = (lvl_i == prev);
  assign nxt       = {bit_d, sh[DW-1:1]};
  assign stuffed   = (ones == OW'(STUFF_RUN));
  assign kill      = se0_i && (bpos != '0);
  assign last_bit  = (bpos == BW'(DW - 1));
  assign full      = (nbytes == NW'(MAX_BYTES));
  assign end_o     = stb_i && kill;
  assign ovf_hit_o = stb_i && !kill && !stuffed && last_bit && full;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= 1'b0;
      ones    <= '0;
      bpos    <= '0;
      nbytes  <= '0;
      sh      <= '0;
      valid_o <= 1'b0;
      byte_o  <= '0;
      eop_o   <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      eop_o   <= 1'b0;
      ovf_o   <= 1'b0;
      if (start_i) begin
        prev   <= 1'b0;
        ones   <= '0;
        bpos   <= '0;
        nbytes <= '0;
        sh     <= '0;
      end else if (stb_i) begin
        if (kill) begin
          eop_o <= 1'b1;
        end else if (stuffed) begin
          ones <= '0;
          prev <= lvl_i;
        end else begin
          prev <= lvl_i;
          ones <= bit_d ? ones + 1'b1 : '0;
          sh   <= nxt;
          if (last_bit) begin
            bpos <= '0;
            if (full) begin
              ovf_o <= 1'b1;
            end else begin
              valid_o <= 1'b1;
              byte_o  <= nxt;
              nbytes  <= nbytes + 1'b1;
            end
          end else begin
            bpos <= bpos + 1'b1;
          end
        end
      end
    end
  end

  // R4: the ones run never exceeds the stuffing threshold
  a_r4_run_bound: assert property (@(posedge clk) disable iff (rst)
    ones <= OW'(STUFF_RUN));

  // R7: delivered byte count never passes the limit
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    nbytes <= NW'(MAX_BYTES));

  // R5: end of packet is a single-clock pulse
  a_r5_eop_pulse: assert property (@(posedge clk) disable iff (rst)
    eop_o |=> !eop_o);

  // R3: byte valid is a single-clock pulse
  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx #(
  parameter int OVS       = 10,
  parameter int MAX_BYTES = 8,
  parameter int SYNC_TMO  = 200,
  parameter int STUFF_RUN = 6,
  parameter int SYNC_FF   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       usb_dp_i,
  input  logic       usb_dm_i,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_eop_o,
  output logic       rx_ovf_o,
  output logic       rx_sync_err_o
);

  localparam int DW = 8;

  logic [1:0] line_s;
  logic       start, stb, lvl, se0, end_pkt, ovf_hit;

  usb_rx_insync #(
    .WIDTH  (2),
    .STAGES (SYNC_FF),
    .RST_VAL(2'b10)
  ) u_sync (
    .clk    (clk),
    .rst    (rst),
    .async_i({usb_dm_i, usb_dp_i}),
    .sync_o (line_s)
  );

  usb_rx_ctrl #(
    .OVS     (OVS),
    .SYNC_TMO(SYNC_TMO)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .dp_i      (line_s[0]),
    .dm_i      (line_s[1]),
    .end_i     (end_pkt),
    .ovf_i     (ovf_hit),
    .start_o   (start),
    .stb_o     (stb),
    .lvl_o     (lvl),
    .se0_o     (se0),
    .sync_err_o(rx_sync_err_o)
  );

  usb_rx_deser #(
    .DW       (DW),
    .MAX_BYTES(MAX_BYTES),
    .STUFF_RUN(STUFF_RUN)
  ) u_deser (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .stb_i    (stb),
    .lvl_i    (lvl),
    .se0_i    (se0),
    .end_o    (end_pkt),
    .ovf_hit_o(ovf_hit),
    .valid_o  (rx_valid_o),
    .byte_o   (rx_byte_o),
    .eop_o    (rx_eop_o),
    .ovf_o    (rx_ovf_o)
  );

  // R9: the four event outputs are mutually exclusive
  a_r9_events_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_valid_o, rx_eop_o, rx_ovf_o, rx_sync_err_o}));

endmodule

// File: tb/usb_ls_rx_tb_top.sv
module usb_ls_rx_tb_top;

  localparam int OVS   = 10;
  localparam int MAXB  = 4;
  localparam int NVEC  = 6;

  // {byte count, bytes packed with byte 0 in bits 7:0}
  localparam logic [34:0] VECS [NVEC] = '{
    {3'd1, 32'h0000_00A5},
    {3'd2, 32'h0000_FF00},
    {3'd4, 32'hFFFF_FFFF},
    {3'd3, 32'h007E_803F},
    {3'd4, 32'hFEC3_3412},
    {3'd2, 32'h0000_FE7F}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dp  = 1'b0;
  logic       dm  = 1'b1;
  logic       rx_valid, rx_eop, rx_ovf, rx_serr;
  logic [7:0] rx_byte;

  int         checks = 0;
  int         fails  = 0;
  logic       lvl    = 1'b0;
  int         ones   = 0;
  logic [7:0] got [16];
  int         got_n  = 0;
  int         eop_n  = 0;
  int         ovf_n  = 0;
  int         serr_n = 0;

  always #5 clk = ~clk;

  usb_ls_rx #(
    .OVS      (OVS),
    .MAX_BYTES(MAXB),
    .SYNC_TMO (200)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .usb_dp_i     (dp),
    .usb_dm_i     (dm),
    .rx_valid_o   (rx_valid),
    .rx_byte_o    (rx_byte),
    .rx_eop_o     (rx_eop),
    .rx_ovf_o     (rx_ovf),
    .rx_sync_err_o(rx_serr)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid && got_n < 16) begin
        got[got_n] = rx_byte;
        got_n++;
      end
      if (rx_eop)  eop_n++;
      if (rx_ovf)  ovf_n++;
      if (rx_serr) serr_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    got_n  = 0;
    eop_n  = 0;
    ovf_n  = 0;
    serr_n = 0;
  endtask

  task automatic slot(input logic dpv, input logic dmv);
    dp = dpv;
    dm = dmv;
    repeat (OVS) @(negedge clk);
  endtask

  task automatic put_lvl(input logic l);
    slot(~l, l);
  endtask

  task automatic put_bit(input logic b);
    if (!b) lvl = ~lvl;
    put_lvl(lvl);
    if (b) ones++; else ones = 0;
    if (ones == 6) begin
      lvl = ~lvl;
      put_lvl(lvl);
      ones = 0;
    end
  endtask

  task automatic put_sync(input int extra);
    for (int i = 0; i < extra; i++) begin
      put_lvl(1'b0);
      put_lvl(1'b1);
    end
    for (int i = 0; i < 3; i++) begin
      put_lvl(1'b0);
      put_lvl(1'b1);
    end
    put_lvl(1'b0);
    put_lvl(1'b0);
    lvl  = 1'b0;
    ones = 0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    for (int j = 0; j < 8; j++) put_bit(v[j]);
  endtask

  task automatic put_eop();
    slot(1'b0, 1'b0);
    slot(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) put_lvl(1'b1);
  endtask

  task automatic send_pkt(input int n, input logic [31:0] d, input int extra);
    put_sync(extra);
    for (int i = 0; i < n; i++) put_byte(d[8*i +: 8]);
    put_eop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] exp2;
    logic       b0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet under reset
    chk({rx_valid, rx_eop, rx_ovf, rx_serr} == 4'b0, "R1 reset", {rx_valid, rx_eop, rx_ovf, rx_serr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({rx_valid, rx_eop, rx_ovf, rx_serr} == 4'b0, "R1 after release", {rx_valid, rx_eop, rx_ovf, rx_serr}, 0);
    repeat (20) @(negedge clk);

    // R3/R4/R5: vector table of packets
    for (int v = 0; v < NVEC; v++) begin
      clear_mon();
      send_pkt(int'(VECS[v][34:32]), VECS[v][31:0], 0);
      chk(got_n == int'(VECS[v][34:32]), "R3 byte count", got_n, int'(VECS[v][34:32]));
      for (int i = 0; i < int'(VECS[v][34:32]); i++)
        chk(got[i] == VECS[v][8*i +: 8], "R3/R4 byte value", got[i], VECS[v][8*i +: 8]);
      chk(eop_n == 1, "R5 eop count", eop_n, 1);
      chk(ovf_n == 0 && serr_n == 0, "R9 no error", ovf_n + serr_n, 0);
    end

    // R2: longer sync preamble still locks on the double K
    clear_mon();
    send_pkt(2, 32'h0000_5AC3, 2);
    chk(got_n == 2, "R2 long sync count", got_n, 2);
    chk(got[0] == 8'hC3 && got[1] == 8'h5A, "R2 long sync bytes", {got[1], got[0]}, 16'h5AC3);

    // R2/R8: lone K never locks and times out
    clear_mon();
    put_lvl(1'b0);
    for (int i = 0; i < 30; i++) put_lvl(1'b1);
    chk(serr_n == 1, "R8 sync error", serr_n, 1);
    chk(got_n == 0 && eop_n == 0, "R2 no lock on lone K", got_n + eop_n, 0);

    // R5: SE0 mid-byte ends packet, partial byte dropped
    clear_mon();
    put_sync(0);
    put_byte(8'h12);
    put_bit(1'b1);
    put_bit(1'b0);
    put_bit(1'b1);
    put_eop();
    chk(got_n == 1 && got[0] == 8'h12, "R5 partial dropped", got_n, 1);
    chk(eop_n == 1, "R5 eop mid byte", eop_n, 1);

    // R6: SE0 in slot 0 decoded as K, packet continues
    clear_mon();
    put_sync(0);
    put_byte(8'h12);
    slot(1'b0, 1'b0);
    b0 = (lvl == 1'b0);
    lvl = 1'b0;
    if (b0) ones++; else ones = 0;
    if (ones == 6) begin
      lvl = ~lvl;
      put_lvl(lvl);
      ones = 0;
    end
    for (int j = 1; j < 8; j++) put_bit(exp2_bit(8'h34, j));
    exp2 = {7'(8'h34 >> 1), b0};
    put_eop();
    chk(got_n == 2, "R6 slot0 SE0 ignored count", got_n, 2);
    chk(got[1] == exp2, "R6 slot0 byte", got[1], exp2);
    chk(eop_n == 1, "R6 single eop", eop_n, 1);

    // R7: too many bytes
    clear_mon();
    put_sync(0);
    for (int i = 0; i < MAXB + 1; i++) put_byte(8'(8'h11 * (i + 1)));
    put_eop();
    chk(got_n == MAXB, "R7 bytes before overflow", got_n, MAXB);
    chk(ovf_n == 1, "R7 overflow pulse", ovf_n, 1);
    chk(eop_n == 0, "R7 no eop after overflow", eop_n, 0);
    clear_mon();
    send_pkt(1, 32'h0000_0069, 0);
    chk(got_n == 1 && got[0] == 8'h69, "R7 recovery packet", got[0], 8'h69);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  function automatic logic exp2_bit(input logic [7:0] v, input int j);
    return v[j];
  endfunction

endmodule